// File: doc/BRIEF.md
# I2C Master Command List Sequencer

This block runs an I2C master transaction described as a short program of command words. Software fills up to sixteen slots, each holding an opcode, a byte count and acknowledge control, and then pulses a start input. The sequencer walks the slots from slot 0 upward. For each slot it issues single-bit operations to a bit-level timing engine over a request/done handshake. It pulls transmit bytes from an input byte stream and pushes received bytes onto an output byte stream. When a slot finishes, the sequencer sets that slot's done flag.

An acknowledge that differs from the expected value (when checking is enabled) aborts the list, and so does a lost arbitration. An END slot pauses without issuing STOP, so the bus stays claimed while new slots and data are loaded. The next start begins again at slot 0. Events are collected in sticky raw flags that are cleared by writing ones to `evt_clr`. A single interrupt line is the OR of the raw flags masked by `evt_en`. The bit order can be chosen separately for transmit and for receive.

States: IDLE (waiting for start), FETCH (decode the current slot), START (issue a start condition), LOAD (take a byte from the transmit stream), TX_BIT (send one data bit), TX_ACK (sample the acknowledge), RX_BIT (sample one data bit), RX_ACK (drive the acknowledge value), STOP (issue a stop condition). Transitions: IDLE→FETCH on start. FETCH→START/LOAD/RX_BIT/STOP by opcode. FETCH→IDLE on END. FETCH→next FETCH on a zero-count WRITE or READ. LOAD→TX_BIT when a byte is offered. TX_BIT→TX_ACK after the eighth bit. TX_ACK→LOAD (more bytes), →next FETCH (count used up) or →IDLE (ack error). RX_BIT→RX_ACK after the eighth bit. RX_ACK→RX_BIT or →next FETCH. START/STOP→next FETCH. Any bit state→IDLE on arbitration loss. "Next FETCH" becomes IDLE after the last slot.

Top module: `i2c_cmdseq`

## Requirements
- R1: After reset, `busy`, `bit_req`, `tx_ready`, `rx_valid`, `irq`, every bit of `evt_raw` and every bit of `cmd_done` are 0.
- R2: A command word has the byte count in bits [7:0], ack-check enable in bit 8, expected ack in bit 9, ack value to drive in bit 10 and the opcode in bits [13:11]. Writing a slot clears its done flag. A slot's done flag (`cmd_done[i]`) sets when the slot completes. After the last slot completes, the sequencer returns to idle.
- R3: Opcode 0 (repeated START) issues one bit operation of code 0 (start condition) and raises event bit 3 (start sent).
- R4: Opcode 1 (WRITE) takes `count` bytes from the transmit stream. For each byte it issues eight bit operations of code 2 (write bit) followed by one of code 3 (read bit) for the acknowledge.
- R5: With `tx_lsb_first`=1, transmit bits go out bit 0 first. With 0, they go out bit 7 first.
- R6: Opcode 2 (READ) issues eight code-3 operations per byte. It assembles the byte in the order set by `rx_lsb_first` (1 = first bit is bit 0). It then issues one code-2 operation carrying the slot's ack value, and pushes the byte with a one-cycle `rx_valid`.
- R7: With ack checking on, an acknowledge bit that differs from the expected value raises event bit 0. The sequencer issues no further operations, the failing slot and later slots stay not done, and it returns to idle. With checking off, the acknowledge is not compared.
- R8: Opcode 3 (STOP) issues one code-1 operation (stop condition) and raises event bit 1.
- R9: Opcode 4 (END, and the unused codes 5 to 7) sets the slot done, raises event bit 2 and returns to idle without a stop condition. A following start resumes at slot 0.
- R10: Each byte written or read, acknowledge included, raises event bit 4.
- R11: When `rx_timeout_limit` is not zero and a received byte takes that many cycles, event bit 5 rises. A zero limit disables the check.
- R12: `bit_arb_lost` together with `bit_done` raises event bit 6 and aborts the list to idle with no further operations.
- R13: Event flags stay set until a 1 is written to the same bit of `evt_clr`. `irq` is 1 exactly when some raw flag is set whose `evt_en` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_wr_en | input | 1 | Write one command slot |
| cmd_wr_idx | input | 4 | Slot index to write |
| cmd_wr_data | input | 14 | Command word fields (see R2) |
| run_start | input | 1 | Pulse: begin execution at slot 0 |
| tx_lsb_first | input | 1 | Transmit bit order |
| rx_lsb_first | input | 1 | Receive bit order |
| rx_timeout_limit | input | 20 | Cycle limit for one received byte, 0 = off |
| tx_valid | input | 1 | Transmit byte available |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmit byte taken this cycle when valid |
| rx_valid | output | 1 | Received byte pulse |
| rx_data | output | 8 | Received byte |
| bit_req | output | 1 | Bit operation requested |
| bit_op | output | 2 | 0 start, 1 stop, 2 write bit, 3 read bit |
| bit_wdata | output | 1 | Bit value for a write bit operation |
| bit_done | input | 1 | Bit operation finished (one cycle) |
| bit_rdata | input | 1 | Bit sampled by a read bit operation |
| bit_arb_lost | input | 1 | Arbitration lost, valid with bit_done |
| busy | output | 1 | Sequencer is executing the list |
| cmd_done | output | 16 | Per-slot done flags |
| evt_raw | output | 7 | Sticky event flags |
| evt_clr | input | 7 | Write-one-to-clear for event flags |
| evt_en | input | 7 | Interrupt enable mask |
| irq | output | 1 | Masked interrupt |

## Verification
A wrong slot index or a bad opcode decode shows up on the next fetch as the wrong bit-operation code on `bit_op`. The bit counter and shift register are exposed by the first byte: a transmit bit-order error is visible on the first write operation, and a receive error shows in the byte pushed on `rx_valid` about nine bit operations later. Faults in the abort paths leave extra operations after the failing one and wrong `cmd_done` bits once `busy` falls. Errors in flag handling appear on `evt_raw` and `irq` one cycle after the event or clear.

// File: rtl/i2c_cmdseq_pkg.sv
`timescale 1ns/1ps
package i2c_cmdseq_pkg;

    localparam int CMD_W = 14;

    localparam logic [2:0] OP_RSTART = 3'd0;
    localparam logic [2:0] OP_WRITE  = 3'd1;
    localparam logic [2:0] OP_READ   = 3'd2;
    localparam logic [2:0] OP_STOP   = 3'd3;
    localparam logic [2:0] OP_END    = 3'd4;

    localparam logic [1:0] BIT_START = 2'd0;
    localparam logic [1:0] BIT_STOP  = 2'd1;
    localparam logic [1:0] BIT_WRITE = 2'd2;
    localparam logic [1:0] BIT_READ  = 2'd3;

    localparam int NUM_EV       = 7;
    localparam int EV_ACK_ERR   = 0;
    localparam int EV_STOP_DONE = 1;
    localparam int EV_END_SEEN  = 2;
    localparam int EV_START     = 3;
    localparam int EV_BYTE      = 4;
    localparam int EV_TIMEOUT   = 5;
    localparam int EV_ARB_LOST  = 6;

    typedef enum logic [3:0] {
        ST_IDLE, ST_FETCH, ST_START, ST_LOAD, ST_TX_BIT,
        ST_TX_ACK, ST_RX_BIT, ST_RX_ACK, ST_STOP
    } seq_state_e;

endpackage

// File: rtl/i2c_cmd_store.sv
`timescale 1ns/1ps
module i2c_cmd_store #(
    parameter int NUM_SLOTS = 16,
    localparam int IW = $clog2(NUM_SLOTS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IW-1:0]                     wr_idx,
    input  logic [i2c_cmdseq_pkg::CMD_W-1:0]  wr_data,
    input  logic [IW-1:0]                     rd_idx,
    output logic [i2c_cmdseq_pkg::CMD_W-1:0]  rd_word,
    input  logic                              set_en,
    output logic [NUM_SLOTS-1:0]              done_vec
);
    import i2c_cmdseq_pkg::*;

    logic [CMD_W-1:0] slot_q [NUM_SLOTS];

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q[g]   <= '0;
                done_vec[g] <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IW'(g)) begin
                    slot_q[g]   <= wr_data;
                    done_vec[g] <= 1'b0;
                end else if (set_en && rd_idx == IW'(g)) begin
                    done_vec[g] <= 1'b1;
                end
            end
        end
    end

    assign rd_word = slot_q[rd_idx];

    // R2: a written slot reads back as not done
    p_write_clears_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !done_vec[$past(wr_idx)]);

endmodule

// File: rtl/i2c_evt_flags.sv
`timescale 1ns/1ps
module i2c_evt_flags #(
    parameter int NEV = 7
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NEV-1:0] ev_i,
    input  logic [NEV-1:0] clr_i,
    input  logic [NEV-1:0] en_i,
    output logic [NEV-1:0] raw_o,
    output logic           irq_o
);
    for (genvar g = 0; g < NEV; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)          raw_o[g] <= 1'b0;
            else if (ev_i[g])    raw_o[g] <= 1'b1;
            else if (clr_i[g])   raw_o[g] <= 1'b0;
        end
    end

    assign irq_o = |(raw_o & en_i);

    // R13: a set flag only drops after a clear request
    p_flags_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(raw_o) & ~$past(clr_i) & ~raw_o) == '0));

    // R13: every event pulse leaves its flag set
    p_event_sets_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(ev_i) & ~raw_o) == '0));

endmodule

// File: rtl/i2c_seq_fsm.sv
`timescale 1ns/1ps
module i2c_seq_fsm #(
    parameter int NUM_SLOTS = 16,
    parameter int TOUT_W    = 20,
    localparam int IW = $clog2(NUM_SLOTS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start_i,
    input  logic [i2c_cmdseq_pkg::CMD_W-1:0]  cmd_i,
    output logic [IW-1:0]                     idx_o,
    output logic                              done_set_o,
    input  logic                              tx_lsb_i,
    input  logic                              rx_lsb_i,
    input  logic [TOUT_W-1:0]                 tout_limit_i,
    input  logic                              tx_valid_i,
    input  logic [7:0]                        tx_data_i,
    output logic                              tx_ready_o,
    output logic                              rx_valid_o,
    output logic [7:0]                        rx_data_o,
    output logic                              bit_req_o,
    output logic [1:0]                        bit_op_o,
    output logic                              bit_wdata_o,
    input  logic                              bit_done_i,
    input  logic                              bit_rdata_i,
    input  logic                              bit_arb_i,
    output logic                              busy_o,
    output logic [i2c_cmdseq_pkg::NUM_EV-1:0] ev_o
);
    import i2c_cmdseq_pkg::*;

    seq_state_e  state_q, state_d;
    logic [7:0]  left_q;
    logic [2:0]  bitcnt_q;
    logic [7:0]  sh_q;
    logic [TOUT_W-1:0] tcnt_q;

    logic [7:0] f_count;
    logic       f_chk, f_exp, f_aval;
    logic [2:0] f_op;
    assign f_count = cmd_i[7:0];
    assign f_chk   = cmd_i[8];
    assign f_exp   = cmd_i[9];
    assign f_aval  = cmd_i[10];
    assign f_op    = cmd_i[13:11];

    logic last_slot, op_ok, ack_bad, adv;
    assign last_slot = (idx_o == IW'(NUM_SLOTS - 1));
    assign op_ok     = bit_done_i && !bit_arb_i;
    assign ack_bad   = f_chk && (bit_rdata_i != f_exp);

    // next state
    always_comb begin
        state_d = state_q;
        adv     = 1'b0;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_FETCH;
            ST_FETCH: begin
                unique case (f_op)
                    OP_RSTART: state_d = ST_START;
                    OP_WRITE:  if (f_count == 8'd0) adv = 1'b1; else state_d = ST_LOAD;
                    OP_READ:   if (f_count == 8'd0) adv = 1'b1; else state_d = ST_RX_BIT;
                    OP_STOP:   state_d = ST_STOP;
                    default:   state_d = ST_IDLE;
                endcase
            end
            ST_START, ST_STOP: begin
                if (bit_done_i) begin
                    if (bit_arb_i) state_d = ST_IDLE;
                    else           adv = 1'b1;
                end
            end
            ST_LOAD:   if (tx_valid_i) state_d = ST_TX_BIT;
            ST_TX_BIT: begin
                if (bit_done_i) begin
                    if (bit_arb_i)              state_d = ST_IDLE;
                    else if (bitcnt_q == 3'd7)  state_d = ST_TX_ACK;
                end
            end
            ST_TX_ACK: begin
                if (bit_done_i) begin
                    if (bit_arb_i || ack_bad)  state_d = ST_IDLE;
                    else if (left_q == 8'd1)   adv = 1'b1;
                    else                       state_d = ST_LOAD;
                end
            end
            ST_RX_BIT: begin
                if (bit_done_i) begin
                    if (bit_arb_i)              state_d = ST_IDLE;
                    else if (bitcnt_q == 3'd7)  state_d = ST_RX_ACK;
                end
            end
            ST_RX_ACK: begin
                if (bit_done_i) begin
                    if (bit_arb_i)             state_d = ST_IDLE;
                    else if (left_q == 8'd1)   adv = 1'b1;
                    else                       state_d = ST_RX_BIT;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (adv) state_d = last_slot ? ST_IDLE : ST_FETCH;
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            idx_o      <= '0;
            left_q     <= '0;
            bitcnt_q   <= '0;
            sh_q       <= '0;
            tcnt_q     <= '0;
            rx_valid_o <= 1'b0;
            rx_data_o  <= '0;
        end else begin
            state_q    <= state_d;
            rx_valid_o <= 1'b0;
            if (state_q == ST_IDLE && start_i) idx_o <= '0;
            else if (adv)                      idx_o <= idx_o + 1'b1;
            if (state_q == ST_FETCH) begin
                left_q   <= f_count;
                bitcnt_q <= '0;
            end
            if (state_q == ST_LOAD && tx_valid_i) begin
                sh_q     <= tx_data_i;
                bitcnt_q <= '0;
            end
            if (state_q == ST_TX_BIT && bit_done_i) bitcnt_q <= bitcnt_q + 1'b1;
            if (state_q == ST_TX_ACK && bit_done_i) left_q   <= left_q - 1'b1;
            if (state_q == ST_RX_BIT && bit_done_i) begin
                if (rx_lsb_i) sh_q[bitcnt_q]        <= bit_rdata_i;
                else          sh_q[3'd7 - bitcnt_q] <= bit_rdata_i;
                bitcnt_q <= bitcnt_q + 1'b1;
            end
            if (state_q == ST_RX_ACK && bit_done_i) begin
                left_q     <= left_q - 1'b1;
                rx_valid_o <= !bit_arb_i;
                rx_data_o  <= sh_q;
            end
            if (state_d == ST_RX_BIT && state_q != ST_RX_BIT)
                tcnt_q <= '0;
            else if ((state_q == ST_RX_BIT || state_q == ST_RX_ACK) && tcnt_q != tout_limit_i)
                tcnt_q <= tcnt_q + 1'b1;
        end
    end

    // outputs
    always_comb begin
        bit_req_o   = 1'b0;
        bit_op_o    = BIT_START;
        bit_wdata_o = 1'b0;
        tx_ready_o  = (state_q == ST_LOAD);
        busy_o      = (state_q != ST_IDLE);
        done_set_o  = adv || (state_q == ST_FETCH && f_op > OP_STOP);
        ev_o        = '0;
        unique case (state_q)
            ST_START:  begin bit_req_o = 1'b1; bit_op_o = BIT_START; end
            ST_STOP:   begin bit_req_o = 1'b1; bit_op_o = BIT_STOP;  end
            ST_TX_BIT: begin
                bit_req_o   = 1'b1;
                bit_op_o    = BIT_WRITE;
                bit_wdata_o = tx_lsb_i ? sh_q[bitcnt_q] : sh_q[3'd7 - bitcnt_q];
            end
            ST_TX_ACK: begin bit_req_o = 1'b1; bit_op_o = BIT_READ; end
            ST_RX_BIT: begin bit_req_o = 1'b1; bit_op_o = BIT_READ; end
            ST_RX_ACK: begin bit_req_o = 1'b1; bit_op_o = BIT_WRITE; bit_wdata_o = f_aval; end
            default: ;
        endcase
        ev_o[EV_START]     = (state_q == ST_START) && op_ok;
        ev_o[EV_STOP_DONE] = (state_q == ST_STOP) && op_ok;
        ev_o[EV_END_SEEN]  = (state_q == ST_FETCH) && (f_op > OP_STOP);
        ev_o[EV_BYTE]      = (state_q == ST_TX_ACK || state_q == ST_RX_ACK) && op_ok;
        ev_o[EV_ACK_ERR]   = (state_q == ST_TX_ACK) && op_ok && ack_bad;
        ev_o[EV_ARB_LOST]  = bit_req_o && bit_done_i && bit_arb_i;
        ev_o[EV_TIMEOUT]   = (state_q == ST_RX_BIT || state_q == ST_RX_ACK)
                             && (tout_limit_i != '0)
                             && (tcnt_q == tout_limit_i - 1'b1);
    end

    // R1/R9: no bit request while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !bit_req_o);

    // R4: no bit operation while waiting for a transmit byte
    p_load_no_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready_o |-> !bit_req_o);

    // R6: a received byte is pushed right after its acknowledge slot
    p_rx_push_after_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |-> ($past(state_q) == ST_RX_ACK && $past(bit_done_i)));

    // R7: ack error aborts to idle
    p_abort_on_ackerr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_o[EV_ACK_ERR] |=> !busy_o);

    // R12: arbitration loss aborts to idle
    p_abort_on_arb_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_req_o && bit_done_i && bit_arb_i) |=> !busy_o);

endmodule

// File: rtl/i2c_cmdseq.sv
`timescale 1ns/1ps
module i2c_cmdseq #(
    parameter int NUM_SLOTS = 16,
    parameter int TOUT_W    = 20,
    localparam int IW  = $clog2(NUM_SLOTS),
    localparam int NEV = i2c_cmdseq_pkg::NUM_EV,
    localparam int CW  = i2c_cmdseq_pkg::CMD_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_wr_en,
    input  logic [IW-1:0]        cmd_wr_idx,
    input  logic [CW-1:0]        cmd_wr_data,
    input  logic                 run_start,
    input  logic                 tx_lsb_first,
    input  logic                 rx_lsb_first,
    input  logic [TOUT_W-1:0]    rx_timeout_limit,
    input  logic                 tx_valid,
    input  logic [7:0]           tx_data,
    output logic                 tx_ready,
    output logic                 rx_valid,
    output logic [7:0]           rx_data,
    output logic                 bit_req,
    output logic [1:0]           bit_op,
    output logic                 bit_wdata,
    input  logic                 bit_done,
    input  logic                 bit_rdata,
    input  logic                 bit_arb_lost,
    output logic                 busy,
    output logic [NUM_SLOTS-1:0] cmd_done,
    output logic [NEV-1:0]       evt_raw,
    input  logic [NEV-1:0]       evt_clr,
    input  logic [NEV-1:0]       evt_en,
    output logic                 irq
);
    logic [IW-1:0]  cur_idx;
    logic [CW-1:0]  cur_word;
    logic           done_set;
    logic [NEV-1:0] ev_pulse;

    i2c_cmd_store #(.NUM_SLOTS(NUM_SLOTS)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cmd_wr_en), .wr_idx(cmd_wr_idx), .wr_data(cmd_wr_data),
        .rd_idx(cur_idx), .rd_word(cur_word),
        .set_en(done_set), .done_vec(cmd_done)
    );

    i2c_seq_fsm #(.NUM_SLOTS(NUM_SLOTS), .TOUT_W(TOUT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_i(run_start), .cmd_i(cur_word),
        .idx_o(cur_idx), .done_set_o(done_set),
        .tx_lsb_i(tx_lsb_first), .rx_lsb_i(rx_lsb_first),
        .tout_limit_i(rx_timeout_limit),
        .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
        .rx_valid_o(rx_valid), .rx_data_o(rx_data),
        .bit_req_o(bit_req), .bit_op_o(bit_op), .bit_wdata_o(bit_wdata),
        .bit_done_i(bit_done), .bit_rdata_i(bit_rdata), .bit_arb_i(bit_arb_lost),
        .busy_o(busy), .ev_o(ev_pulse)
    );

    i2c_evt_flags #(.NEV(NEV)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .ev_i(ev_pulse), .clr_i(evt_clr), .en_i(evt_en),
        .raw_o(evt_raw), .irq_o(irq)
    );

endmodule

// File: tb/i2c_cmdseq_tb_top.sv
`timescale 1ns/1ps
module i2c_cmdseq_tb_top;
    import i2c_cmdseq_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [3:0]  cmd_wr_idx = '0;
    logic [13:0] cmd_wr_data = '0;
    logic        run_start = 1'b0;
    logic        tx_lsb_first = 1'b0, rx_lsb_first = 1'b0;
    logic [19:0] rx_timeout_limit = 20'd1000;
    logic        tx_valid = 1'b1;
    logic [7:0]  tx_data;
    logic        tx_ready, rx_valid, bit_req, bit_wdata, busy, irq;
    logic [7:0]  rx_data;
    logic [1:0]  bit_op;
    logic        bit_done, bit_rdata, bit_arb_lost;
    logic [15:0] cmd_done;
    logic [6:0]  evt_raw;
    logic [6:0]  evt_clr = '0, evt_en = '0;

    i2c_cmdseq dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_wr_en(cmd_wr_en), .cmd_wr_idx(cmd_wr_idx),
        .cmd_wr_data(cmd_wr_data), .run_start(run_start),
        .tx_lsb_first(tx_lsb_first), .rx_lsb_first(rx_lsb_first),
        .rx_timeout_limit(rx_timeout_limit), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .bit_req(bit_req), .bit_op(bit_op), .bit_wdata(bit_wdata),
        .bit_done(bit_done), .bit_rdata(bit_rdata), .bit_arb_lost(bit_arb_lost),
        .busy(busy), .cmd_done(cmd_done), .evt_raw(evt_raw),
        .evt_clr(evt_clr), .evt_en(evt_en), .irq(irq)
    );

    // bit engine model and stream logs
    logic       log_clr = 1'b0;
    int         eng_lat = 2;
    int         arb_at = -1;
    logic       rd_bits [256];
    logic [7:0] tx_mem  [16];
    logic [1:0] ops     [256];
    logic       wr_bits [256];
    logic [7:0] rx_log  [16];
    int n_ops, n_wr, n_rd, n_rx, tx_ptr, eng_cnt;
    logic eng_busy, cur_arb;
    logic [1:0] cur_op;

    assign tx_data = tx_mem[tx_ptr[3:0]];

    always @(posedge clk) begin
        if (!rst_n || log_clr) begin
            eng_busy <= 1'b0; bit_done <= 1'b0; bit_rdata <= 1'b0; bit_arb_lost <= 1'b0;
            n_ops <= 0; n_wr <= 0; n_rd <= 0; n_rx <= 0; tx_ptr <= 0; eng_cnt <= 0;
            cur_arb <= 1'b0; cur_op <= '0;
        end else begin
            bit_done <= 1'b0;
            bit_arb_lost <= 1'b0;
            if (tx_valid && tx_ready) tx_ptr <= tx_ptr + 1;
            if (rx_valid) begin rx_log[n_rx[3:0]] <= rx_data; n_rx <= n_rx + 1; end
            if (!eng_busy && bit_req && !bit_done) begin
                eng_busy <= 1'b1;
                eng_cnt  <= eng_lat;
                cur_op   <= bit_op;
                cur_arb  <= (n_ops == arb_at);
                ops[n_ops[7:0]] <= bit_op;
                n_ops <= n_ops + 1;
                if (bit_op == BIT_WRITE) begin
                    wr_bits[n_wr[7:0]] <= bit_wdata;
                    n_wr <= n_wr + 1;
                end
            end else if (eng_busy) begin
                if (eng_cnt == 0) begin
                    eng_busy     <= 1'b0;
                    bit_done     <= 1'b1;
                    bit_arb_lost <= cur_arb;
                    if (cur_op == BIT_READ) begin
                        bit_rdata <= rd_bits[n_rd[7:0]];
                        n_rd <= n_rd + 1;
                    end else bit_rdata <= 1'b0;
                end else eng_cnt <= eng_cnt - 1;
            end
        end
    end

    int checks = 0, errors = 0;

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] cw(input logic [2:0] op, input logic [7:0] n,
                                       input logic chk_en, input logic exp_ack, input logic val);
        return {op, val, exp_ack, chk_en, n};
    endfunction

    task automatic wr_slot(input int i, input logic [13:0] w);
        @(negedge clk);
        cmd_wr_en = 1'b1; cmd_wr_idx = i[3:0]; cmd_wr_data = w;
        @(negedge clk);
        cmd_wr_en = 1'b0;
    endtask

    task automatic prep();
        @(negedge clk);
        log_clr = 1'b1; evt_clr = '1;
        for (int i = 0; i < 256; i++) rd_bits[i] = 1'b0;
        @(negedge clk);
        log_clr = 1'b0; evt_clr = '0;
    endtask

    task automatic run_list();
        int g;
        @(negedge clk); run_start = 1'b1;
        @(negedge clk); run_start = 1'b0;
        g = 0;
        while (busy && g < 20000) begin @(negedge clk); g++; end
        checks++;
        if (busy) begin errors++; $display("FAIL R9 list did not return idle actual 1 expected 0"); end
        repeat (3) @(negedge clk);
    endtask

    // {lsb_first, data}
    localparam logic [8:0] TXV [6] = '{9'h0A5, 9'h1A5, 9'h001, 9'h180, 9'h0FF, 9'h13C};

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!busy && !bit_req && !tx_ready && !rx_valid && !irq, "R1 idle outputs",
            {busy, bit_req, tx_ready, rx_valid, irq}, 0);
        chk(evt_raw == 0 && cmd_done == 0, "R1 flags", {evt_raw, cmd_done}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table: single byte write, bit order R4/R5/R10
        for (int v = 0; v < 6; v++) begin
            logic [7:0] got, expb, d;
            logic lsb;
            d = TXV[v][7:0]; lsb = TXV[v][8];
            prep();
            tx_lsb_first = lsb; tx_mem[0] = d;
            wr_slot(0, cw(OP_WRITE, 8'd1, 1'b1, 1'b0, 1'b0));
            wr_slot(1, cw(OP_END, 8'd0, 1'b0, 1'b0, 1'b0));
            run_list();
            for (int b = 0; b < 8; b++) begin
                got[b]  = wr_bits[b];
                expb[b] = lsb ? d[b] : d[7 - b];
            end
            chk(got == expb && n_wr == 8, "R5 tx bit order", {24'd0, got}, {24'd0, expb});
            chk(n_ops == 9 && ops[8] == BIT_READ, "R4 write op count", n_ops, 9);
            chk(evt_raw[EV_BYTE] && evt_raw[EV_END_SEEN] && cmd_done[1:0] == 2'b11,
                "R10 byte and end flags", {evt_raw, cmd_done}, 0);
        end

        // full transaction R3/R4/R6/R8/R2
        prep();
        tx_lsb_first = 1'b0; rx_lsb_first = 1'b0;
        tx_mem[0] = 8'h12; tx_mem[1] = 8'h34;
        for (int b = 0; b < 8; b++) begin
            rd_bits[2 + b]  = 8'hA5 >> (7 - b);
            rd_bits[10 + b] = 8'h3C >> (7 - b);
        end
        wr_slot(0, cw(OP_RSTART, 8'd0, 1'b0, 1'b0, 1'b0));
        wr_slot(1, cw(OP_WRITE, 8'd2, 1'b1, 1'b0, 1'b0));
        wr_slot(2, cw(OP_READ, 8'd1, 1'b0, 1'b0, 1'b0));
        wr_slot(3, cw(OP_READ, 8'd1, 1'b0, 1'b0, 1'b1));
        wr_slot(4, cw(OP_STOP, 8'd0, 1'b0, 1'b0, 1'b0));
        wr_slot(5, cw(OP_END, 8'd0, 1'b0, 1'b0, 1'b0));
        run_list();
        chk(ops[0] == BIT_START && evt_raw[EV_START], "R3 start op", {30'd0, ops[0]}, BIT_START);
        chk(n_ops == 38 && ops[37] == BIT_STOP && evt_raw[EV_STOP_DONE], "R8 stop op", n_ops, 38);
        chk(n_rx == 2 && rx_log[0] == 8'hA5 && rx_log[1] == 8'h3C, "R6 msb-first bytes",
            {rx_log[0], rx_log[1]}, 16'hA53C);
        chk(n_wr == 18 && wr_bits[16] == 1'b0 && wr_bits[17] == 1'b1, "R6 ack values driven",
            {wr_bits[16], wr_bits[17]}, 2'b01);
        chk(cmd_done[5:0] == 6'h3F && !evt_raw[EV_ACK_ERR], "R2 done flags", cmd_done, 16'h003F);
        chk(!evt_raw[EV_TIMEOUT], "R11 no timeout under limit", evt_raw, 0);

        // receive lsb-first R6
        prep();
        rx_lsb_first = 1'b1;
        for (int b = 0; b < 8; b++) rd_bits[b] = 8'hC1 >> b;
        wr_slot(0, cw(OP_READ, 8'd1, 1'b0, 1'b0, 1'b1));
        wr_slot(1, cw(OP_END, 8'd0, 1'b0, 1'b0, 1'b0));
        run_list();
        chk(n_rx == 1 && rx_log[0] == 8'hC1, "R6 lsb-first byte", rx_log[0], 8'hC1);

        // ack error abort R7
        prep();
        rd_bits[0] = 1'b1;
        wr_slot(0, cw(OP_WRITE, 8'd2, 1'b1, 1'b0, 1'b0));
        wr_slot(1, cw(OP_STOP, 8'd0, 1'b0, 1'b0, 1'b0));
        wr_slot(2, cw(OP_END, 8'd0, 1'b0, 1'b0, 1'b0));
        run_list();
        chk(evt_raw[EV_ACK_ERR] && n_ops == 9, "R7 abort after nack", n_ops, 9);
        chk(cmd_done[2:0] == 3'b000, "R7 no slot done", cmd_done, 0);

        // ack check disabled R7
        prep();
        rd_bits[0] = 1'b1;
        wr_slot(0, cw(OP_WRITE, 8'd1, 1'b0, 1'b0, 1'b0));
        wr_slot(1, cw(OP_END, 8'd0, 1'b0, 1'b0, 1'b0));
        run_list();
        chk(!evt_raw[EV_ACK_ERR] && cmd_done[1:0] == 2'b11, "R7 unchecked ack ignored",
            {evt_raw, cmd_done}, 16'h0003);

        // END pause then resume at slot 0 R9/R2
        chk(!(n_ops > 0 && ops[n_ops - 1] == BIT_STOP), "R9 end issues no stop", n_ops, 9);
        wr_slot(0, cw(OP_STOP, 8'd0, 1'b0, 1'b0, 1'b0));
        chk(cmd_done[0] == 1'b0 && cmd_done[1] == 1'b1, "R2 write clears done", cmd_done, 16'h0002);
        prep();
        run_list();
        chk(n_ops == 1 && ops[0] == BIT_STOP && cmd_done[1:0] == 2'b11, "R9 resume at slot 0",
            n_ops, 1);

        // timeout R11
        prep();
        eng_lat = 20; rx_timeout_limit = 20'd30;
        wr_slot(0, cw(OP_READ, 8'd1, 1'b0, 1'b0, 1'b1));
        wr_slot(1, cw(OP_END, 8'd0, 1'b0, 1'b0, 1'b0));
        run_list();
        chk(evt_raw[EV_TIMEOUT] == 1'b1, "R11 timeout flag", evt_raw, 7'h20);
        eng_lat = 2; rx_timeout_limit = 20'd1000;

        // arbitration loss R12
        prep();
        arb_at = 3;
        wr_slot(0, cw(OP_RSTART, 8'd0, 1'b0, 1'b0, 1'b0));
        wr_slot(1, cw(OP_WRITE, 8'd1, 1'b0, 1'b0, 1'b0));
        wr_slot(2, cw(OP_STOP, 8'd0, 1'b0, 1'b0, 1'b0));
        wr_slot(3, cw(OP_END, 8'd0, 1'b0, 1'b0, 1'b0));
        run_list();
        arb_at = -1;
        chk(evt_raw[EV_ARB_LOST] && n_ops == 4, "R12 abort on arb loss", n_ops, 4);
        chk(cmd_done[3:0] == 4'b0001, "R12 done flags", cmd_done, 16'h0001);

        // sticky flags, clear and mask R13
        @(negedge clk); evt_en = '0;
        @(negedge clk);
        chk(irq == 1'b0, "R13 masked irq", irq, 0);
        evt_en = 7'h40;
        @(negedge clk);
        chk(irq == 1'b1, "R13 enabled irq", irq, 1);
        evt_clr = 7'h40;
        @(negedge clk); evt_clr = '0;
        @(negedge clk);
        chk(evt_raw[EV_ARB_LOST] == 1'b0 && evt_raw[EV_START] == 1'b1 && irq == 1'b0,
            "R13 one-bit clear", evt_raw, 7'h08);
        evt_en = '0;

        // list without END runs through all slots R2
        prep();
        for (int s = 0; s < 16; s++) wr_slot(s, cw(OP_STOP, 8'd0, 1'b0, 1'b0, 1'b0));
        run_list();
        chk(n_ops == 16 && cmd_done == 16'hFFFF && !busy, "R2 last slot ends list",
            {n_ops[15:0], cmd_done}, {16'd16, 16'hFFFF});

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual timeout expected finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule